// File: doc/BRIEF.md
# Color Palette Lookup Core

This block is the digital heart of a palette-based video converter. A small processor port, steered by three register-select lines, reaches an address register, a 256-entry red/green/blue palette, a bank of overlay color registers, a pixel read mask and an 8-bit command register. Palette and overlay entries are moved one component at a time. Red, green and blue follow each other in turn, and the address register steps forward once the blue component of an entry has been handled.

On the pixel side, a new pixel is taken on every clock. In indexed mode the 8-bit pixel index is ANDed with the read mask and then looked up in the palette. In direct-color mode a 15-bit red/green/blue word goes straight through and skips both the palette and the mask. A nonzero overlay select replaces the result with one of the overlay registers. The three registered 8-bit codes feed the digital-to-analog converters. The command register chooses between 6-bit and 8-bit color data and between indexed and direct color. The command register has no reset value, so software must program it before use.

Top module: `paletteCore`

## Requirements
- R1: While reset is held, and after it is released, the address register reads 0, the read mask reads 0xFF and all three color outputs are 0. The command register has no defined value until it is written.
- R2: The register-select codes are as follows: 0 is the address register, 1 is palette data, 2 is the read mask, 4 is overlay data and 5 is the command register. Codes 3, 6 and 7 read as 0, and writes to them change no register.
- R3: Palette data writes fill red, then green, then blue. The entry at the address register is written with all three values when blue arrives, and the address then increments. A write to the address register restarts the sequence at red.
- R4: Palette data reads return red, green and blue of the addressed entry in turn. The address increments after blue. Read data appears on the clock edge that samples the read strobe.
- R5: The address register wraps from 255 to 0 after the blue component of entry 255.
- R6: With command bit 0 clear (6-bit mode), color data writes store only data bits 5..0, with bits 7..6 taken as 0. Color data reads return 0 in bits 7..6.
- R7: In 6-bit mode the two low bits of every output code are 0. A palette or overlay value v is sent as {v[5:0],00}. In 8-bit mode (command bit 0 set) the stored value is sent unchanged.
- R8: With command bit 1 clear (indexed mode), the pixel index ANDed with the read mask selects the palette entry. A pixel sampled at clock edge k appears on the outputs after edge k+1.
- R9: With command bit 1 set (direct-color mode), the pixel word {red[14:10], green[9:5], blue[4:0]} is output with the same latency. Each 5-bit value c becomes {c, c[4:2]}, and the palette and the read mask have no effect.
- R10: Overlay data access (select 4) uses the same red/green/blue sequence and address increment. Address bits 1..0 pick one of four overlay registers. A nonzero overlay select n outputs overlay register n, and an overlay select of 0 keeps the normal path.
- R11: If the blue palette write for an entry happens at the same clock edge at which that entry is looked up, the outputs carry the newly written values.
- R12: The command register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 3 | Register select |
| cpuWr | input | 1 | Write strobe, one clock per access |
| cpuRd | input | 1 | Read strobe, one clock per access |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data, registered |
| pixIdx | input | 8 | Pixel index (indexed mode) |
| pixDirect | input | 15 | Direct-color pixel {red, green, blue} |
| ovlSel | input | 2 | Overlay select, 0 for the normal path |
| dacRed | output | 8 | Red code to converter |
| dacGrn | output | 8 | Green code to converter |
| dacBlu | output | 8 | Blue code to converter |

## Verification
The bench interrupts a palette write after red and then reloads the address. A design that failed to restart the sequence would commit shifted components to the wrong entry. It writes entry 255 to catch an address that fails to wrap, and switches to 6-bit mode to catch stored or read-back bits 7..6 and nonzero output low bits. Direct-color tests run with a zero mask to expose a path that still applies the mask or the palette. A blue write that coincides with a lookup of the same entry catches a design that shows the stale entry for one clock.

// File: rtl/paletteCorePkg.sv
package paletteCorePkg;
  localparam int IDX_W     = 8;
  localparam int COMP_W    = 8;
  localparam int DIR_W     = 5;
  localparam int OVL_W     = 2;
  localparam int NUM_OVL   = 1 << OVL_W;
  localparam int ENTRY_W   = 3 * COMP_W;
  localparam int PAL_DEPTH = 1 << IDX_W;
  localparam int NARROW_W  = 6;

  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_PAL  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_RSV3 = 3'd3,
    SEL_OVL  = 3'd4,
    SEL_CMD  = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } compSeq_e;

  // control -> datapath strobes and settings
  typedef struct packed {
    logic               palWe;
    logic               ovlWe;
    logic [IDX_W-1:0]   addr;
    logic [ENTRY_W-1:0] wrData;
    logic [IDX_W-1:0]   readMask;
    logic               eightBit;
    logic               directMode;
  } ctrlStrobes_t;
endpackage

// File: rtl/paletteCtrl.sv
module paletteCtrl
  import paletteCorePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         cpuSel,
  input  logic               cpuWr,
  input  logic               cpuRd,
  input  logic [7:0]         cpuWdata,
  output logic [7:0]         cpuRdata,
  input  logic [ENTRY_W-1:0] palRdEntry,
  input  logic [ENTRY_W-1:0] ovlRdEntry,
  output ctrlStrobes_t       strb
);
  regSel_e             sel;
  compSeq_e            comp;
  logic [IDX_W-1:0]    addr;
  logic [IDX_W-1:0]    mask;
  logic [7:0]          cmdReg;
  logic [COMP_W-1:0]   holdR, holdG;
  logic [COMP_W-1:0]   wrAdj;
  logic [COMP_W-1:0]   palComp, ovlComp;
  logic [7:0]          rdMux;
  logic                eightBit;
  logic                colorSel;

  assign sel      = regSel_e'(cpuSel);
  assign eightBit = cmdReg[0];
  assign colorSel = (sel == SEL_PAL) || (sel == SEL_OVL);

  // 6-bit mode keeps only the low bits of written color data
  assign wrAdj = eightBit ? cpuWdata : {{(COMP_W-NARROW_W){1'b0}}, cpuWdata[NARROW_W-1:0]};

  function automatic logic [COMP_W-1:0] pickComp(input logic [ENTRY_W-1:0] e,
                                                 input compSeq_e c, input logic wide);
    logic [COMP_W-1:0] v;
    case (c)
      COMP_RED: v = e[2*COMP_W +: COMP_W];
      COMP_GRN: v = e[COMP_W +: COMP_W];
      default:  v = e[0 +: COMP_W];
    endcase
    if (!wide) v[COMP_W-1:NARROW_W] = '0;
    return v;
  endfunction

  assign palComp = pickComp(palRdEntry, comp, eightBit);
  assign ovlComp = pickComp(ovlRdEntry, comp, eightBit);

  always_comb begin
    case (sel)
      SEL_ADDR: rdMux = addr;
      SEL_PAL:  rdMux = palComp;
      SEL_MASK: rdMux = mask;
      SEL_OVL:  rdMux = ovlComp;
      SEL_CMD:  rdMux = cmdReg;
      default:  rdMux = '0;
    endcase
  end

  // command register: no reset value, software programs it
  always_ff @(posedge clk) begin
    if (cpuWr && sel == SEL_CMD) cmdReg <= cpuWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr     <= '0;
      comp     <= COMP_RED;
      holdR    <= '0;
      holdG    <= '0;
      mask     <= '1;
      cpuRdata <= '0;
    end else if (cpuWr) begin
      case (sel)
        SEL_ADDR: begin
          addr <= cpuWdata[IDX_W-1:0];
          comp <= COMP_RED;
        end
        SEL_MASK: mask <= cpuWdata[IDX_W-1:0];
        SEL_PAL, SEL_OVL: begin
          case (comp)
            COMP_RED: begin holdR <= wrAdj; comp <= COMP_GRN; end
            COMP_GRN: begin holdG <= wrAdj; comp <= COMP_BLU; end
            default:  begin comp <= COMP_RED; addr <= addr + 1'b1; end
          endcase
        end
        default: ;
      endcase
    end else if (cpuRd) begin
      cpuRdata <= rdMux;
      if (colorSel) begin
        case (comp)
          COMP_RED: comp <= COMP_GRN;
          COMP_GRN: comp <= COMP_BLU;
          default:  begin comp <= COMP_RED; addr <= addr + 1'b1; end
        endcase
      end
    end
  end

  always_comb begin
    strb.palWe      = cpuWr && (sel == SEL_PAL) && (comp == COMP_BLU);
    strb.ovlWe      = cpuWr && (sel == SEL_OVL) && (comp == COMP_BLU);
    strb.addr       = addr;
    strb.wrData     = {holdR, holdG, wrAdj};
    strb.readMask   = mask;
    strb.eightBit   = eightBit;
    strb.directMode = cmdReg[1];
  end
endmodule

// File: rtl/paletteDatapath.sv
module paletteDatapath
  import paletteCorePkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [IDX_W-1:0]       pixIdx,
  input  logic [3*DIR_W-1:0]     pixDirect,
  input  logic [OVL_W-1:0]       ovlSel,
  output logic [ENTRY_W-1:0]     palRdEntry,
  output logic [ENTRY_W-1:0]     ovlRdEntry,
  output logic [COMP_W-1:0]      dacRed,
  output logic [COMP_W-1:0]      dacGrn,
  output logic [COMP_W-1:0]      dacBlu
);
  logic [ENTRY_W-1:0] palMem [PAL_DEPTH];
  logic [ENTRY_W-1:0] ovlReg [NUM_OVL];

  logic [IDX_W-1:0]   s1Idx;
  logic [3*DIR_W-1:0] s1Dir;
  logic [OVL_W-1:0]   s1Ovl;

  logic [ENTRY_W-1:0] lookEntry, dirEntry, srcEntry, fmtEntry;
  logic               useDirect;

  always_ff @(posedge clk) begin
    if (strb.palWe) palMem[strb.addr] <= strb.wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_OVL; i++) ovlReg[i] <= '0;
    end else if (strb.ovlWe) begin
      ovlReg[strb.addr[OVL_W-1:0]] <= strb.wrData;
    end
  end

  assign palRdEntry = palMem[strb.addr];
  assign ovlRdEntry = ovlReg[strb.addr[OVL_W-1:0]];

  // stage 1: capture masked index, direct word and overlay select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Idx <= '0;
      s1Dir <= '0;
      s1Ovl <= '0;
    end else begin
      s1Idx <= pixIdx & strb.readMask;
      s1Dir <= pixDirect;
      s1Ovl <= ovlSel;
    end
  end

  // stage 2: lookup with write bypass, source select, width formatting
  assign lookEntry = (strb.palWe && strb.addr == s1Idx) ? strb.wrData : palMem[s1Idx];
  assign useDirect = (s1Ovl == '0) && strb.directMode;
  assign srcEntry  = (s1Ovl != '0) ? ovlReg[s1Ovl] : (useDirect ? dirEntry : lookEntry);

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [COMP_W-1:0] v;
    assign dirEntry[c*COMP_W +: COMP_W] =
      {s1Dir[c*DIR_W +: DIR_W], s1Dir[c*DIR_W+DIR_W-1 -: COMP_W-DIR_W]};
    assign v = srcEntry[c*COMP_W +: COMP_W];
    assign fmtEntry[c*COMP_W +: COMP_W] =
      strb.eightBit ? v :
      useDirect     ? {v[COMP_W-1:COMP_W-NARROW_W], {(COMP_W-NARROW_W){1'b0}}} :
                      {v[NARROW_W-1:0], {(COMP_W-NARROW_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacRed <= '0;
      dacGrn <= '0;
      dacBlu <= '0;
    end else begin
      dacRed <= fmtEntry[2*COMP_W +: COMP_W];
      dacGrn <= fmtEntry[COMP_W +: COMP_W];
      dacBlu <= fmtEntry[0 +: COMP_W];
    end
  end
endmodule

// File: rtl/paletteCore.sv
module paletteCore
  import paletteCorePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cpuSel,
  input  logic        cpuWr,
  input  logic        cpuRd,
  input  logic [7:0]  cpuWdata,
  output logic [7:0]  cpuRdata,
  input  logic [7:0]  pixIdx,
  input  logic [14:0] pixDirect,
  input  logic [1:0]  ovlSel,
  output logic [7:0]  dacRed,
  output logic [7:0]  dacGrn,
  output logic [7:0]  dacBlu
);
  ctrlStrobes_t       strb;
  logic [ENTRY_W-1:0] palRdEntry;
  logic [ENTRY_W-1:0] ovlRdEntry;

  paletteCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .palRdEntry(palRdEntry),
    .ovlRdEntry(ovlRdEntry), .strb(strb)
  );

  paletteDatapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIdx(pixIdx), .pixDirect(pixDirect),
    .ovlSel(ovlSel), .palRdEntry(palRdEntry), .ovlRdEntry(ovlRdEntry),
    .dacRed(dacRed), .dacGrn(dacGrn), .dacBlu(dacBlu)
  );
endmodule

// File: rtl/paletteCoreChecker.sv
module paletteCoreChecker
  import paletteCorePkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   cpuSel,
  input logic         cpuWr,
  input logic         cpuRd,
  input logic [7:0]   cpuWdata,
  input logic [7:0]   cpuRdata,
  input logic [14:0]  pixDirect,
  input logic [1:0]   ovlSel,
  input logic [7:0]   dacRed,
  input logic [7:0]   dacGrn,
  input logic [7:0]   dacBlu,
  input ctrlStrobes_t strb
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_addr_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuSel == 3'd0) |=> strb.addr == $past(cpuWdata));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.palWe || strb.ovlWe) |=> strb.addr == $past(strb.addr) + IDX_W'(1));

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuSel == 3'd2) |=> strb.readMask == $past(cpuWdata));

  p_narrow_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr && (cpuSel == 3'd1 || cpuSel == 3'd4) && !strb.eightBit)
    |=> cpuRdata[7:6] == 2'b00);

  p_narrow_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.palWe || strb.ovlWe) && !strb.eightBit) |->
    (strb.wrData[23:22] == 2'b00 && strb.wrData[15:14] == 2'b00 && strb.wrData[7:6] == 2'b00));

  p_narrow_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && $past(!strb.eightBit)) |->
    (dacRed[1:0] == 2'b00 && dacGrn[1:0] == 2'b00 && dacBlu[1:0] == 2'b00));

  p_direct_path_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && $past(strb.directMode) && $past(strb.eightBit) && $past(ovlSel, 2) == 2'd0) |->
    (dacRed == {$past(pixDirect[14:10], 2), $past(pixDirect[14:12], 2)} &&
     dacGrn == {$past(pixDirect[9:5], 2),   $past(pixDirect[9:7], 2)} &&
     dacBlu == {$past(pixDirect[4:0], 2),   $past(pixDirect[4:2], 2)}));
endmodule

bind paletteCore paletteCoreChecker chk_i (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
  .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .pixDirect(pixDirect), .ovlSel(ovlSel),
  .dacRed(dacRed), .dacGrn(dacGrn), .dacBlu(dacBlu), .strb(strb)
);

// File: tb/paletteCore_tb_top.sv
`timescale 1ns/1ps
module paletteCore_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cpuSel = '0;
  logic        cpuWr = 1'b0;
  logic        cpuRd = 1'b0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic [7:0]  pixIdx = '0;
  logic [14:0] pixDirect = '0;
  logic [1:0]  ovlSel = '0;
  logic [7:0]  dacRed, dacGrn, dacBlu;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  paletteCore dut_i (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .pixIdx(pixIdx), .pixDirect(pixDirect),
    .ovlSel(ovlSel), .dacRed(dacRed), .dacGrn(dacGrn), .dacBlu(dacBlu)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkRgb(input string tag, input logic [7:0] r, input logic [7:0] g,
                          input logic [7:0] b);
    check8({tag, " red"}, dacRed, r);
    check8({tag, " green"}, dacGrn, g);
    check8({tag, " blue"}, dacBlu, b);
  endtask

  task automatic cpuWrite(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cpuSel = s; cpuWdata = d; cpuWr = 1'b1;
    @(posedge clk); #1;
    cpuWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    cpuSel = s; cpuRd = 1'b1;
    @(posedge clk); #1;
    d = cpuRdata;
    cpuRd = 1'b0;
  endtask

  task automatic writeEntry(input logic [2:0] s, input logic [7:0] a,
                            input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    cpuWrite(3'd0, a);
    cpuWrite(s, r);
    cpuWrite(s, g);
    cpuWrite(s, b);
  endtask

  task automatic readEntry(input string tag, input logic [2:0] s, input logic [7:0] a,
                           input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    logic [7:0] d;
    cpuWrite(3'd0, a);
    cpuRead(s, d); check8({tag, " read red"}, d, r);
    cpuRead(s, d); check8({tag, " read green"}, d, g);
    cpuRead(s, d); check8({tag, " read blue"}, d, b);
  endtask

  task automatic pixel(input string tag, input logic [7:0] idx, input logic [14:0] dir,
                       input logic [1:0] ov, input logic [7:0] r, input logic [7:0] g,
                       input logic [7:0] b);
    @(negedge clk);
    pixIdx = idx; pixDirect = dir; ovlSel = ov;
    @(posedge clk);
    @(posedge clk); #1;
    checkRgb(tag, r, g, b);
  endtask

  task automatic testReset();
    logic [7:0] d;
    #20;
    checkRgb("R1 in reset", 8'h00, 8'h00, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkRgb("R1 after reset", 8'h00, 8'h00, 8'h00);
    cpuRead(3'd0, d); check8("R1 address", d, 8'h00);
    cpuRead(3'd2, d); check8("R1 mask", d, 8'hFF);
  endtask

  task automatic testCommand();
    logic [7:0] d;
    cpuWrite(3'd5, 8'hA5);
    cpuRead(3'd5, d); check8("R12 command readback", d, 8'hA5);
    cpuWrite(3'd5, 8'h01);
    cpuRead(3'd5, d); check8("R12 command readback", d, 8'h01);
  endtask

  task automatic testPaletteAccess();
    logic [7:0] d;
    writeEntry(3'd1, 8'd10, 8'h11, 8'h22, 8'h33);
    cpuWrite(3'd1, 8'h44); cpuWrite(3'd1, 8'h55); cpuWrite(3'd1, 8'h66);
    cpuRead(3'd0, d); check8("R3 address after two entries", d, 8'd12);
    readEntry("R4 entry10", 3'd1, 8'd10, 8'h11, 8'h22, 8'h33);
    cpuRead(3'd1, d); check8("R4 entry11 red", d, 8'h44);
    cpuRead(3'd1, d); check8("R4 entry11 green", d, 8'h55);
    cpuRead(3'd1, d); check8("R4 entry11 blue", d, 8'h66);
    cpuRead(3'd0, d); check8("R4 address after reads", d, 8'd12);
    // sequence restart on address write
    cpuWrite(3'd0, 8'd40); cpuWrite(3'd1, 8'h10);
    writeEntry(3'd1, 8'd41, 8'h21, 8'h22, 8'h23);
    readEntry("R3 restart entry41", 3'd1, 8'd41, 8'h21, 8'h22, 8'h23);
  endtask

  task automatic testReserved();
    logic [7:0] d;
    cpuWrite(3'd0, 8'd12);
    cpuWrite(3'd3, 8'h77); cpuWrite(3'd6, 8'h78); cpuWrite(3'd7, 8'h79);
    cpuRead(3'd3, d); check8("R2 select3 reads zero", d, 8'h00);
    cpuRead(3'd7, d); check8("R2 select7 reads zero", d, 8'h00);
    cpuRead(3'd0, d); check8("R2 address untouched", d, 8'd12);
    cpuRead(3'd2, d); check8("R2 mask untouched", d, 8'hFF);
    cpuRead(3'd5, d); check8("R2 command untouched", d, 8'h01);
  endtask

  task automatic testIndexed();
    pixel("R8 index 11 full mask", 8'h0B, 15'h0, 2'd0, 8'h44, 8'h55, 8'h66);
    cpuWrite(3'd2, 8'hFE);
    pixel("R8 index 11 masked to 10", 8'h0B, 15'h0, 2'd0, 8'h11, 8'h22, 8'h33);
    cpuWrite(3'd2, 8'hFF);
  endtask

  task automatic testWrap();
    logic [7:0] d;
    writeEntry(3'd1, 8'hFF, 8'h9A, 8'hBC, 8'hDE);
    cpuRead(3'd0, d); check8("R5 address wraps", d, 8'h00);
    pixel("R5 entry255 lookup", 8'hFF, 15'h0, 2'd0, 8'h9A, 8'hBC, 8'hDE);
  endtask

  task automatic testNarrow();
    cpuWrite(3'd5, 8'h00);
    writeEntry(3'd1, 8'd20, 8'hFF, 8'hC1, 8'h3F);
    readEntry("R6 entry20", 3'd1, 8'd20, 8'h3F, 8'h01, 8'h3F);
    readEntry("R6 entry11", 3'd1, 8'd11, 8'h04, 8'h15, 8'h26);
    pixel("R7 entry20 narrow", 8'd20, 15'h0, 2'd0, 8'hFC, 8'h04, 8'hFC);
    pixel("R7 entry10 narrow", 8'd10, 15'h0, 2'd0, 8'h44, 8'h88, 8'hCC);
  endtask

  task automatic testDirect();
    cpuWrite(3'd5, 8'h03);
    cpuWrite(3'd2, 8'h00);
    pixel("R9 direct wide", 8'd10, {5'b10110, 5'b00001, 5'b11111}, 2'd0,
          8'hB5, 8'h08, 8'hFF);
    pixel("R9 direct other", 8'd11, {5'b00011, 5'b11000, 5'b01010}, 2'd0,
          8'h18, 8'hC6, 8'h52);
    cpuWrite(3'd5, 8'h02);
    pixel("R7 direct narrow", 8'd10, {5'b10110, 5'b00001, 5'b11111}, 2'd0,
          8'hB4, 8'h08, 8'hFC);
    cpuWrite(3'd2, 8'hFF);
    cpuWrite(3'd5, 8'h01);
  endtask

  task automatic testOverlay();
    logic [7:0] d;
    writeEntry(3'd4, 8'd2, 8'h12, 8'h34, 8'h56);
    cpuRead(3'd0, d); check8("R10 address after overlay write", d, 8'd3);
    pixel("R10 overlay 2", 8'd10, 15'h0, 2'd2, 8'h12, 8'h34, 8'h56);
    pixel("R10 overlay 1 cleared", 8'd10, 15'h0, 2'd1, 8'h00, 8'h00, 8'h00);
    pixel("R10 overlay off", 8'd10, 15'h0, 2'd0, 8'h11, 8'h22, 8'h33);
    readEntry("R10 overlay2", 3'd4, 8'd2, 8'h12, 8'h34, 8'h56);
  endtask

  task automatic testBypass();
    writeEntry(3'd1, 8'd30, 8'h01, 8'h02, 8'h03);
    pixel("R11 before update", 8'd30, 15'h0, 2'd0, 8'h01, 8'h02, 8'h03);
    cpuWrite(3'd0, 8'd30);
    cpuWrite(3'd1, 8'hA0);
    cpuWrite(3'd1, 8'hB0);
    checkRgb("R11 partial write invisible", 8'h01, 8'h02, 8'h03);
    cpuWrite(3'd1, 8'hC0);
    checkRgb("R11 same-edge write", 8'hA0, 8'hB0, 8'hC0);
  endtask

  initial begin
    testReset();
    testCommand();
    testPaletteAccess();
    testReserved();
    testIndexed();
    testWrap();
    testNarrow();
    cpuWrite(3'd5, 8'h01);
    testDirect();
    testOverlay();
    testBypass();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule